// File: doc/BRIEF.md
# Predicated Vector Immediate Broadcast Unit

This block writes a small signed constant into selected lanes of a vector register. The constant is given as an 8-bit signed field with an optional left shift by eight, and the lane width is chosen by a 2-bit size code. A byte-granular predicate decides which lanes receive the constant. Lanes that are not selected pass through the current destination contents unchanged, so the block can sit directly between a register read port and a write port.

One encoding is reserved: byte lanes together with the shift. The block raises a flag for it and returns the destination untouched. The vector length is a compile-time parameter, and it must be a multiple of 64 bits. A parameter also chooses between a registered result with one cycle of latency, which is the default, and a purely combinational path.

Top module: `vec_imm_bcast`

## Requirements
- R1: The size code sets the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes. There are VEC_W divided by the lane width lanes, and lane k occupies bits [k*W +: W].
- R2: The constant is the 8-bit field sign-extended to 64 bits. When the shift input is 1, the constant is then shifted left by 8 bits.
- R3: `undef_o` is 1 exactly when the size code is 2'b00 and the shift input is 1. For every other combination it is 0.
- R4: Every active lane receives the low W bits of the constant, which truncates it to the lane width.
- R5: Every inactive lane keeps the value it has on `dest_i`.
- R6: A lane is active when the predicate bit at its lowest byte index (lane index times W/8) is 1. The other predicate bits that fall inside the lane have no effect.
- R7: For the reserved encoding, `res_o` equals `dest_i` and no lane is written.
- R8: With the default OUT_REG=1, the outputs appear one clock after the inputs are presented. While `rst_n` is low, `res_o` and `undef_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| size_i | input | 2 | Lane width code |
| shift_i | input | 1 | Shift the constant left by 8 when 1 |
| imm8_i | input | 8 | Signed 8-bit constant field |
| dest_i | input | VEC_W | Current destination vector |
| pred_i | input | VEC_W/8 | Governing predicate, one bit per byte |
| res_o | output | VEC_W | Resulting vector |
| undef_o | output | 1 | Reserved encoding flag |

## Verification
Each of the four lane widths is exercised with the constants -128, 0 and 127, both unshifted and shifted, using random destinations and random predicates. These cases separate sign extension from zero extension, show where the shifted constant is truncated in the wider lanes, and catch a lane mapping that is wrong for one width only. An all-ones predicate and an all-zeros predicate separate the write path from the merge path. A pattern with a 1 on every byte except the lowest byte of each lane proves that only the lowest predicate bit of a lane counts. The reserved encoding is applied with a full predicate, so any lane written by mistake becomes visible.

// File: rtl/vec_imm_bcast_pkg.sv
package vec_imm_bcast_pkg;

   localparam int unsigned NUM_SIZES = 4;
   localparam int unsigned MAX_LANE_W = 64;

   typedef enum logic [1:0] {
      LW_B8  = 2'b00,
      LW_B16 = 2'b01,
      LW_B32 = 2'b10,
      LW_B64 = 2'b11
   } lane_w_e;

   function automatic int unsigned lane_width(input int unsigned code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/vec_imm_gen.sv
module vec_imm_gen
   import vec_imm_bcast_pkg::*;
(
   input  logic [1:0]            size_i,
   input  logic                  shift_i,
   input  logic [7:0]            imm8_i,
   output logic [MAX_LANE_W-1:0] imm_o,
   output logic                  undef_o
);

   logic [MAX_LANE_W-1:0] sext;

   always_comb begin
      sext  = {{(MAX_LANE_W-8){imm8_i[7]}}, imm8_i};
      imm_o = shift_i ? (sext << 8) : sext;
   end

   assign undef_o = (lane_w_e'(size_i) == LW_B8) && shift_i;

   // R2: the shifted form always has a zero low byte
   always_comb begin
      a_r2_shift_low_zero: assert (!shift_i || imm_o[7:0] == 8'h00);
   end

endmodule

// File: rtl/vec_lane_merge.sv
module vec_lane_merge #(
   parameter int unsigned VEC_W  = 256,
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANE_W-1:0]       imm_i,
   input  logic [VEC_W/LANE_W-1:0] act_i,
   input  logic [VEC_W-1:0]        dest_i,
   output logic [VEC_W-1:0]        vec_o
);

   localparam int unsigned LANES = VEC_W / LANE_W;

   if (LANE_W % 8 != 0 || VEC_W % LANE_W != 0) begin : g_bad_cfg
      $error("vec_lane_merge: lane width does not tile the vector");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign vec_o[l*LANE_W +: LANE_W] =
         act_i[l] ? imm_i : dest_i[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/vec_imm_bcast.sv
module vec_imm_bcast
   import vec_imm_bcast_pkg::*;
#(
   parameter int unsigned VEC_W   = 256,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         size_i,
   input  logic               shift_i,
   input  logic [7:0]         imm8_i,
   input  logic [VEC_W-1:0]   dest_i,
   input  logic [VEC_W/8-1:0] pred_i,
   output logic [VEC_W-1:0]   res_o,
   output logic               undef_o
);

   localparam int unsigned BYTES = VEC_W / 8;

   if (VEC_W < 64 || VEC_W % 64 != 0) begin : g_bad_vl
      $error("vec_imm_bcast: VEC_W must be a nonzero multiple of 64");
   end

   logic [MAX_LANE_W-1:0] imm_full;
   logic                  undef_c;
   logic [VEC_W-1:0]      cand [NUM_SIZES];
   logic [VEC_W-1:0]      res_c;

   vec_imm_gen u_imm (
      .size_i  (size_i),
      .shift_i (shift_i),
      .imm8_i  (imm8_i),
      .imm_o   (imm_full),
      .undef_o (undef_c)
   );

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int unsigned LW = lane_width(s);
      localparam int unsigned NL = VEC_W / LW;
      logic [NL-1:0] act;
      for (genvar l = 0; l < NL; l++) begin : g_act
         assign act[l] = pred_i[l*(LW/8)];
      end
      vec_lane_merge #(.VEC_W(VEC_W), .LANE_W(LW)) u_merge (
         .imm_i  (imm_full[LW-1:0]),
         .act_i  (act),
         .dest_i (dest_i),
         .vec_o  (cand[s])
      );
   end

   assign res_c = undef_c ? dest_i : cand[size_i];

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_o   <= '0;
            undef_o <= 1'b0;
         end else begin
            res_o   <= res_c;
            undef_o <= undef_c;
         end
      end

      a_r3_undef_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (size_i == 2'b00) |=> (undef_o == $past(shift_i)));
      a_r3_no_undef_wide: assert property (@(posedge clk) disable iff (!rst_n)
         (size_i != 2'b00) |=> !undef_o);
      a_r7_reserved_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
         (size_i == 2'b00 && shift_i) |=> (res_o == $past(dest_i)));

      for (genvar b = 0; b < BYTES; b++) begin : g_byte_chk
         a_r4_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i == 2'b00 && !shift_i && pred_i[b])
            |=> (res_o[b*8 +: 8] == $past(imm8_i)));
         a_r5_byte_merge: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i == 2'b00 && !pred_i[b])
            |=> (res_o[b*8 +: 8] == $past(dest_i[b*8 +: 8])));
      end
   end else begin : g_comb
      assign res_o   = res_c;
      assign undef_o = undef_c;
   end

endmodule

// File: tb/vec_imm_bcast_tb_top.sv
module vec_imm_bcast_tb_top;

   localparam int unsigned VEC_W      = 256;
   localparam int unsigned BYTES      = VEC_W / 8;
   localparam time         CLK_PERIOD = 10ns;
   localparam int          WD_LIMIT   = 100000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [1:0]         size_i = '0;
   logic               shift_i = 1'b0;
   logic [7:0]         imm8_i = '0;
   logic [VEC_W-1:0]   dest_i = '0;
   logic [BYTES-1:0]   pred_i = '0;
   logic [VEC_W-1:0]   res_o;
   logic               undef_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_imm_bcast #(.VEC_W(VEC_W), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .size_i(size_i), .shift_i(shift_i),
      .imm8_i(imm8_i), .dest_i(dest_i), .pred_i(pred_i),
      .res_o(res_o), .undef_o(undef_o)
   );

   function automatic logic [VEC_W-1:0] rand_vec();
      logic [VEC_W-1:0] v;
      for (int i = 0; i < VEC_W/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [BYTES-1:0] rand_pred();
      logic [BYTES-1:0] p;
      for (int i = 0; i < BYTES; i++) p[i] = 1'($urandom);
      return p;
   endfunction

   function automatic logic [VEC_W-1:0] model(input logic [1:0] sz, input logic sh,
         input logic [7:0] i8, input logic [VEC_W-1:0] d, input logic [BYTES-1:0] p);
      logic [63:0] k;
      logic [VEC_W-1:0] r;
      int w;
      k = {{56{i8[7]}}, i8};
      if (sh) k = k << 8;
      w = 8 << sz;
      r = d;
      if (sz == 2'b00 && sh) return d;
      for (int b = 0; b < VEC_W; b++) begin
         if (p[(b / w) * (w / 8)]) r[b] = k[b % w];
      end
      return r;
   endfunction

   task automatic check_vec(input string req, input logic [VEC_W-1:0] act,
         input logic [VEC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s res_o actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s undef_o actual=%b expected=%b", req, act, exp);
      end
   endtask

   // apply at negedge, result registered at next posedge, sample at following negedge
   task automatic apply_and_check(input string req, input logic [1:0] sz, input logic sh,
         input logic [7:0] i8, input logic [VEC_W-1:0] d, input logic [BYTES-1:0] p);
      size_i = sz; shift_i = sh; imm8_i = i8; dest_i = d; pred_i = p;
      @(posedge clk);
      @(negedge clk);
      check_vec(req, res_o, model(sz, sh, i8, d, p));
      check_bit(req, undef_o, (sz == 2'b00) && sh);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      dest_i = rand_vec(); pred_i = '1; imm8_i = 8'h55;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_vec("R8 reset", res_o, '0);
      check_bit("R8 reset", undef_o, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_imm_sweep();
      logic [7:0] imms [3] = '{8'h80, 8'h00, 8'h7F};
      for (int s = 0; s < 4; s++)
         for (int h = 0; h < 2; h++)
            for (int i = 0; i < 3; i++)
               for (int r = 0; r < 3; r++)
                  apply_and_check("R1 R2 R4 R5 sweep", 2'(s), 1'(h), imms[i],
                                  rand_vec(), rand_pred());
   endtask

   task automatic t_full_and_empty();
      for (int s = 0; s < 4; s++) begin
         apply_and_check("R4 all active", 2'(s), 1'b0, 8'hA5, rand_vec(), '1);
         apply_and_check("R5 none active", 2'(s), 1'b1, 8'h3C, rand_vec(), '0);
      end
   endtask

   task automatic t_ignored_pred_bits();
      for (int s = 1; s < 4; s++) begin
         logic [BYTES-1:0] p;
         int step = (8 << s) / 8;
         logic [VEC_W-1:0] d = rand_vec();
         p = '1;
         for (int b = 0; b < BYTES; b += step) p[b] = 1'b0;
         // R6: only non-lowest bits set, so every lane must stay as dest
         apply_and_check("R6 upper bits ignored", 2'(s), 1'b0, 8'h81, d, p);
         check_vec("R6 dest kept", res_o, d);
      end
   endtask

   task automatic t_reserved();
      for (int r = 0; r < 3; r++) begin
         logic [VEC_W-1:0] d = rand_vec();
         apply_and_check("R3 R7 reserved", 2'b00, 1'b1, 8'(r * 50 + 1), d, '1);
         check_vec("R7 no lane written", res_o, d);
      end
   endtask

   task automatic t_random();
      for (int r = 0; r < 200; r++)
         apply_and_check("R1 R2 R3 R4 R5 random", 2'($urandom), 1'($urandom),
                         8'($urandom), rand_vec(), rand_pred());
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      @(negedge clk);
      t_imm_sweep();
      t_full_and_empty();
      t_ignored_pred_bits();
      t_reserved();
      t_random();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WD_LIMIT && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule